// File: doc/BRIEF.md
# Dual-Core Word Exchange Mailbox

This block moves 24-bit words and a small set of signal bits between two processor cores, called side A and side B, that share one clock. Each direction has one FIFO, and that FIFO lives on the receiving side. A write on the sender's port pushes the word straight into the peer's receive queue, so the sender has no transmit buffer of its own. The queue from A to B holds 10 words and the queue from B to A holds 24. Each core pops its own queue through a read port whose data is valid in the same cycle as the read strobe.

Each direction also carries a 4-bit flag word. The sender writes it and the receiver sees it. Every flag bit that changes marks a pending event on the receiving side. Each side has a status view: its receive fill count, the free space left in the peer's queue, a sticky overflow bit and a sticky underflow bit. A per-side interrupt is the OR of the sources that side has enabled.

Top module: `ipx_mailbox`

## Requirements
- R1: Words written by side A come out of side B's read port in the order they were written, all 24 bits intact. The same holds from B to A.
- R2: The A-to-B queue accepts exactly 10 words. Once it holds 10 and no pop happens in the same cycle, a further write is dropped and the stored words are unchanged.
- R3: The B-to-A queue accepts exactly 24 words. A further write is dropped the same way.
- R4: A dropped write sets the sender's sticky overflow bit in the cycle after the write. The bit stays set until the sender writes one to clear bit 0, and it clears in the cycle after that write.
- R5: A read from an empty queue returns zero and leaves the pointers unchanged, so the next word pushed is the next word read. The read sets the reader's sticky underflow bit, which clears on a write of one to clear bit 1.
- R6: A push and a pop on the same non-empty queue in one cycle leave the fill count unchanged and keep the word order.
- R7: The receive fill count and the peer free-space count change in the cycle after a push or pop.
- R8: A write to a side's flag port appears on the peer's flag input in the next cycle.
- R9: When a flag write changes a bit, that bit's pending event is set on the receiving side in the next cycle. A write that leaves a bit unchanged sets nothing. A pending event clears when the receiver writes one to clear bit 2+i.
- R10: The interrupt enable bits are: bit 0 for a non-empty receive queue, bit 1 for a receive count at or above a non-zero threshold, bit 2 for free space in the peer queue, and bits 3 to 6 for pending flag events 0 to 3. The interrupt output is high exactly when an enabled source is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_wr_en | input | 1 | Side A pushes a word to B |
| a_wr_data | input | 24 | Word from side A |
| a_rd_en | input | 1 | Side A pops its receive queue |
| a_rd_data | output | 24 | Head of A's receive queue, zero when the queue is empty |
| a_flag_wr_en | input | 1 | Side A writes its outgoing flags |
| a_flag_wr_data | input | 4 | Flag value from side A |
| a_flag_in | output | 4 | Flags written by side B |
| a_clr | input | 6 | Write-one-to-clear: bit 0 overflow, bit 1 underflow, bits 5:2 flag events |
| a_irq_en | input | 7 | Side A interrupt enables |
| a_rx_thresh | input | 5 | Side A receive threshold, 0 disables the source |
| a_rx_count | output | 5 | Words in A's receive queue |
| a_peer_free | output | 4 | Free slots in B's receive queue |
| a_ovf | output | 1 | Sticky overflow, side A |
| a_unf | output | 1 | Sticky underflow, side A |
| a_irq | output | 1 | Side A interrupt |
| b_wr_en | input | 1 | Side B pushes a word to A |
| b_wr_data | input | 24 | Word from side B |
| b_rd_en | input | 1 | Side B pops its receive queue |
| b_rd_data | output | 24 | Head of B's receive queue, zero when the queue is empty |
| b_flag_wr_en | input | 1 | Side B writes its outgoing flags |
| b_flag_wr_data | input | 4 | Flag value from side B |
| b_flag_in | output | 4 | Flags written by side A |
| b_clr | input | 6 | Write-one-to-clear, same layout as a_clr |
| b_irq_en | input | 7 | Side B interrupt enables |
| b_rx_thresh | input | 4 | Side B receive threshold, 0 disables the source |
| b_rx_count | output | 4 | Words in B's receive queue |
| b_peer_free | output | 5 | Free slots in A's receive queue |
| b_ovf | output | 1 | Sticky overflow, side B |
| b_unf | output | 1 | Sticky underflow, side B |
| b_irq | output | 1 | Side B interrupt |

## Verification
The bench builds the block with its default parameters. Those give a 10-word queue, which is not a power of two, and a 24-word queue, which is also not a power of two, so both queues use the wrap-by-compare pointer variant. These small depths let the bench fill each queue completely, push one more word to cause an overflow, and drain it again within a few dozen cycles. The 4-bit flag width lets the bench check a bit that changes and a bit that is rewritten with the same value as separate cases.

// File: rtl/ipx_pkg.sv
package ipx_pkg;
   // Interrupt source positions inside the per-side enable mask
   localparam int SRC_NONEMPTY = 0;
   localparam int SRC_THRESH   = 1;
   localparam int SRC_SPACE    = 2;
   localparam int SRC_FLAG0    = 3;

   function automatic int cnt_width(input int depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/ipx_fifo.sv
module ipx_fifo #(
   parameter int WIDTH = 24,
   parameter int DEPTH = 10,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] pop_data,
   output logic [CNT_W-1:0] count,
   output logic             push_drop,
   output logic             pop_empty
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wp, rp, wp_nxt, rp_nxt;
   logic             empty, full, do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign do_pop  = pop & ~empty;
   assign do_push = push & (~full | do_pop);

   assign push_drop = push & ~do_push;
   assign pop_empty = pop & empty;
   assign pop_data  = empty ? '0 : mem[rp];

   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2_wrap
         assign wp_nxt = wp + 1'b1;
         assign rp_nxt = rp + 1'b1;
      end else begin : g_cmp_wrap
         assign wp_nxt = (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nxt = (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp_nxt;
         if (do_pop)  rp <= rp_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH)); // R2
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && count == CNT_W'(DEPTH)) |=> $stable(count)); // R3
   AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && count == '0) |=> (count == '0)); // R5
   AST_SIMUL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && count != '0) |=> $stable(count)); // R6
endmodule

// File: rtl/ipx_side.sv
module ipx_side
   import ipx_pkg::*;
#(
   parameter int FLAG_W = 4,
   parameter int RX_CNT_W = 5,
   localparam int NSRC = SRC_FLAG0 + FLAG_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_drop,
   input  logic                rd_empty,
   input  logic [FLAG_W+1:0]   clr,
   input  logic                flag_wr_en,
   input  logic [FLAG_W-1:0]   flag_wr_data,
   input  logic [FLAG_W-1:0]   flag_chg_in,
   input  logic [RX_CNT_W-1:0] rx_count,
   input  logic [RX_CNT_W-1:0] rx_thresh,
   input  logic                peer_space,
   input  logic [NSRC-1:0]     irq_en,
   output logic [FLAG_W-1:0]   flag_out,
   output logic [FLAG_W-1:0]   flag_chg_out,
   output logic                ovf,
   output logic                unf,
   output logic                irq
);
   logic [FLAG_W-1:0] pend;
   logic [NSRC-1:0]   src;
   logic              thr_hit;

   assign flag_chg_out = flag_wr_en ? (flag_wr_data ^ flag_out) : '0;
   assign thr_hit      = (rx_thresh != '0) && (rx_count >= rx_thresh);

   assign src[SRC_NONEMPTY] = (rx_count != '0);
   assign src[SRC_THRESH]   = thr_hit;
   assign src[SRC_SPACE]    = peer_space;
   assign src[NSRC-1:SRC_FLAG0] = pend;
   assign irq = |(src & irq_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_out <= '0;
         pend     <= '0;
         ovf      <= 1'b0;
         unf      <= 1'b0;
      end else begin
         if (flag_wr_en) flag_out <= flag_wr_data;
         pend <= (pend & ~clr[FLAG_W+1:2]) | flag_chg_in;
         ovf  <= (ovf & ~clr[0]) | wr_drop;
         unf  <= (unf & ~clr[1]) | rd_empty;
      end
   end

   AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      wr_drop |=> ovf); // R4
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr[0]) |=> ovf); // R4
   AST_UNF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      rd_empty |=> unf); // R5
   AST_FLAG_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_chg_in != '0) |=> ((pend & $past(flag_chg_in)) == $past(flag_chg_in))); // R9
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en == '0) |-> !irq); // R10
endmodule

// File: rtl/ipx_mailbox.sv
module ipx_mailbox
   import ipx_pkg::*;
#(
   parameter int DATA_W   = 24,
   parameter int FLAG_W   = 4,
   parameter int DEPTH_AB = 10,
   parameter int DEPTH_BA = 24,
   localparam int CNT_AB_W = $clog2(DEPTH_AB + 1),
   localparam int CNT_BA_W = $clog2(DEPTH_BA + 1),
   localparam int NSRC     = SRC_FLAG0 + FLAG_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                a_wr_en,
   input  logic [DATA_W-1:0]   a_wr_data,
   input  logic                a_rd_en,
   output logic [DATA_W-1:0]   a_rd_data,
   input  logic                a_flag_wr_en,
   input  logic [FLAG_W-1:0]   a_flag_wr_data,
   output logic [FLAG_W-1:0]   a_flag_in,
   input  logic [FLAG_W+1:0]   a_clr,
   input  logic [NSRC-1:0]     a_irq_en,
   input  logic [CNT_BA_W-1:0] a_rx_thresh,
   output logic [CNT_BA_W-1:0] a_rx_count,
   output logic [CNT_AB_W-1:0] a_peer_free,
   output logic                a_ovf,
   output logic                a_unf,
   output logic                a_irq,
   input  logic                b_wr_en,
   input  logic [DATA_W-1:0]   b_wr_data,
   input  logic                b_rd_en,
   output logic [DATA_W-1:0]   b_rd_data,
   input  logic                b_flag_wr_en,
   input  logic [FLAG_W-1:0]   b_flag_wr_data,
   output logic [FLAG_W-1:0]   b_flag_in,
   input  logic [FLAG_W+1:0]   b_clr,
   input  logic [NSRC-1:0]     b_irq_en,
   input  logic [CNT_AB_W-1:0] b_rx_thresh,
   output logic [CNT_AB_W-1:0] b_rx_count,
   output logic [CNT_BA_W-1:0] b_peer_free,
   output logic                b_ovf,
   output logic                b_unf,
   output logic                b_irq
);
   generate
      if (DEPTH_AB < 2 || DEPTH_BA < 2) begin : g_bad_depth
         $error("ipx_mailbox: both queue depths must be at least 2");
      end
      if (DATA_W < 1 || FLAG_W < 1) begin : g_bad_width
         $error("ipx_mailbox: data and flag widths must be positive");
      end
   endgenerate

   logic ab_drop, ab_empty_rd, ba_drop, ba_empty_rd;
   logic [FLAG_W-1:0] a_chg, b_chg;

   // A -> B queue, owned by side B
   ipx_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH_AB)) u_q_ab (
      .clk(clk), .rst_n(rst_n),
      .push(a_wr_en), .push_data(a_wr_data),
      .pop(b_rd_en), .pop_data(b_rd_data),
      .count(b_rx_count), .push_drop(ab_drop), .pop_empty(ab_empty_rd)
   );

   // B -> A queue, owned by side A
   ipx_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH_BA)) u_q_ba (
      .clk(clk), .rst_n(rst_n),
      .push(b_wr_en), .push_data(b_wr_data),
      .pop(a_rd_en), .pop_data(a_rd_data),
      .count(a_rx_count), .push_drop(ba_drop), .pop_empty(ba_empty_rd)
   );

   assign a_peer_free = CNT_AB_W'(DEPTH_AB) - b_rx_count;
   assign b_peer_free = CNT_BA_W'(DEPTH_BA) - a_rx_count;

   ipx_side #(.FLAG_W(FLAG_W), .RX_CNT_W(CNT_BA_W)) u_side_a (
      .clk(clk), .rst_n(rst_n),
      .wr_drop(ab_drop), .rd_empty(ba_empty_rd), .clr(a_clr),
      .flag_wr_en(a_flag_wr_en), .flag_wr_data(a_flag_wr_data),
      .flag_chg_in(b_chg), .rx_count(a_rx_count), .rx_thresh(a_rx_thresh),
      .peer_space(a_peer_free != '0), .irq_en(a_irq_en),
      .flag_out(b_flag_in), .flag_chg_out(a_chg),
      .ovf(a_ovf), .unf(a_unf), .irq(a_irq)
   );

   ipx_side #(.FLAG_W(FLAG_W), .RX_CNT_W(CNT_AB_W)) u_side_b (
      .clk(clk), .rst_n(rst_n),
      .wr_drop(ba_drop), .rd_empty(ab_empty_rd), .clr(b_clr),
      .flag_wr_en(b_flag_wr_en), .flag_wr_data(b_flag_wr_data),
      .flag_chg_in(a_chg), .rx_count(b_rx_count), .rx_thresh(b_rx_thresh),
      .peer_space(b_peer_free != '0), .irq_en(b_irq_en),
      .flag_out(a_flag_in), .flag_chg_out(b_chg),
      .ovf(b_ovf), .unf(b_unf), .irq(b_irq)
   );

   AST_FREE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      (a_wr_en && !b_rd_en && b_rx_count != CNT_AB_W'(DEPTH_AB))
         |=> (a_peer_free == $past(a_peer_free) - 1'b1)); // R7
   AST_FLAG_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      a_flag_wr_en |=> (b_flag_in == $past(a_flag_wr_data))); // R8
endmodule

// File: tb/ipx_mailbox_tb.sv
module ipx_mailbox_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 24, FW = 4, DAB = 10, DBA = 24;
   localparam int CAB = $clog2(DAB + 1), CBA = $clog2(DBA + 1);
   localparam int NS = 3 + FW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic a_wr_en = 0, a_rd_en = 0, a_flag_wr_en = 0;
   logic b_wr_en = 0, b_rd_en = 0, b_flag_wr_en = 0;
   logic [DW-1:0] a_wr_data = '0, b_wr_data = '0, a_rd_data, b_rd_data;
   logic [FW-1:0] a_flag_wr_data = '0, b_flag_wr_data = '0, a_flag_in, b_flag_in;
   logic [FW+1:0] a_clr = '0, b_clr = '0;
   logic [NS-1:0] a_irq_en = '0, b_irq_en = '0;
   logic [CBA-1:0] a_rx_thresh = '0, a_rx_count, b_peer_free;
   logic [CAB-1:0] b_rx_thresh = '0, b_rx_count, a_peer_free;
   logic a_ovf, a_unf, a_irq, b_ovf, b_unf, b_irq;

   int n_checks = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ipx_mailbox u_dut (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push_a(input logic [DW-1:0] d);
      @(negedge clk); a_wr_en = 1; a_wr_data = d;
      @(negedge clk); a_wr_en = 0;
   endtask
   task automatic push_b(input logic [DW-1:0] d);
      @(negedge clk); b_wr_en = 1; b_wr_data = d;
      @(negedge clk); b_wr_en = 0;
   endtask
   task automatic pop_b(input string req, input logic [DW-1:0] exp);
      @(negedge clk); b_rd_en = 1; #1 check(req, b_rd_data, exp);
      @(negedge clk); b_rd_en = 0;
   endtask
   task automatic pop_a(input string req, input logic [DW-1:0] exp);
      @(negedge clk); a_rd_en = 1; #1 check(req, a_rd_data, exp);
      @(negedge clk); a_rd_en = 0;
   endtask

   task automatic t_reset;
      check("R7 reset b_rx_count", b_rx_count, 0);
      check("R7 reset a_peer_free", a_peer_free, DAB);
      check("R7 reset b_peer_free", b_peer_free, DBA);
      check("R4 reset ovf", {a_ovf, b_ovf}, 0);
      check("R10 reset irq", {a_irq, b_irq}, 0);
   endtask

   task automatic t_order;
      push_a(24'hA00001); push_a(24'hFFFFFF); push_a(24'h123456);
      check("R7 b_rx_count after 3 pushes", b_rx_count, 3);
      check("R7 a_peer_free after 3 pushes", a_peer_free, DAB - 3);
      pop_b("R1 order word0", 24'hA00001);
      check("R7 count after pop", b_rx_count, 2);
      pop_b("R1 order word1", 24'hFFFFFF);
      pop_b("R1 order word2", 24'h123456);
      push_b(24'h0BEEF0); pop_a("R1 B to A word", 24'h0BEEF0);
   endtask

   task automatic t_fill_ab;
      a_irq_en = NS'(1 << 2);
      @(negedge clk); check("R10 peer space irq", a_irq, 1);
      for (int i = 0; i < DAB + 1; i++) push_a(DW'(24'h100 + i));
      check("R2 full count", b_rx_count, DAB);
      check("R2 peer free zero", a_peer_free, 0);
      check("R4 overflow set", a_ovf, 1);
      check("R10 space irq drops when full", a_irq, 0);
      for (int i = 0; i < DAB; i++) pop_b("R2 drained word", DW'(24'h100 + i));
      check("R4 overflow stays", a_ovf, 1);
      @(negedge clk); a_clr = 6'b000001;
      @(negedge clk); a_clr = '0;
      check("R4 overflow cleared", a_ovf, 0);
      a_irq_en = '0;
   endtask

   task automatic t_fill_ba;
      for (int i = 0; i < DBA + 1; i++) push_b(DW'(24'h5000 + i));
      check("R3 full count", a_rx_count, DBA);
      check("R3 overflow set", b_ovf, 1);
      for (int i = 0; i < DBA; i++) pop_a("R3 drained word", DW'(24'h5000 + i));
      check("R3 empty after drain", a_rx_count, 0);
      @(negedge clk); b_clr = 6'b000001;
      @(negedge clk); b_clr = '0;
   endtask

   task automatic t_underflow;
      @(negedge clk); b_rd_en = 1; #1 check("R5 empty read zero", b_rd_data, 0);
      @(negedge clk); b_rd_en = 0;
      check("R5 underflow set", b_unf, 1);
      check("R5 count stays zero", b_rx_count, 0);
      push_a(24'h777777);
      pop_b("R5 pointers unchanged", 24'h777777);
      @(negedge clk); b_clr = 6'b000010;
      @(negedge clk); b_clr = '0;
      check("R5 underflow cleared", b_unf, 0);
   endtask

   task automatic t_simul;
      push_a(24'h000011); push_a(24'h000022);
      @(negedge clk); a_wr_en = 1; a_wr_data = 24'h000033; b_rd_en = 1;
      #1 check("R6 head during simul", b_rd_data, 24'h000011);
      @(negedge clk); a_wr_en = 0; b_rd_en = 0;
      check("R6 count unchanged", b_rx_count, 2);
      pop_b("R6 order word1", 24'h000022);
      pop_b("R6 order word2", 24'h000033);
   endtask

   task automatic t_flags;
      b_irq_en = NS'(1 << 3);
      @(negedge clk); a_flag_wr_en = 1; a_flag_wr_data = 4'b0101;
      @(negedge clk); a_flag_wr_en = 0;
      check("R8 flags visible", b_flag_in, 4'b0101);
      check("R9 flag0 event irq", b_irq, 1);
      @(negedge clk); b_clr = 6'b000100;
      @(negedge clk); b_clr = '0;
      check("R9 flag0 event cleared", b_irq, 0);
      @(negedge clk); a_flag_wr_en = 1; a_flag_wr_data = 4'b0101;
      @(negedge clk); a_flag_wr_en = 0;
      check("R9 same value sets nothing", b_irq, 0);
      @(negedge clk); a_flag_wr_en = 1; a_flag_wr_data = 4'b0100;
      @(negedge clk); a_flag_wr_en = 0;
      check("R9 flag0 change again", b_irq, 1);
      b_irq_en = '0;
      #1 check("R10 masked", b_irq, 0);
      @(negedge clk); b_clr = 6'b111100;
      @(negedge clk); b_clr = '0;
      @(negedge clk); b_flag_wr_en = 1; b_flag_wr_data = 4'b1000;
      @(negedge clk); b_flag_wr_en = 0;
      check("R8 flags B to A", a_flag_in, 4'b1000);
   endtask

   task automatic t_irq;
      b_irq_en = NS'(1 << 1); b_rx_thresh = 3;
      push_a(1); push_a(2);
      check("R10 below threshold", b_irq, 0);
      push_a(3);
      check("R10 threshold reached", b_irq, 1);
      b_irq_en = NS'(1);
      #1 check("R10 nonempty source", b_irq, 1);
      pop_b("R1 word", 1); pop_b("R1 word", 2); pop_b("R1 word", 3);
      check("R10 empty no irq", b_irq, 0);
      b_irq_en = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset;
      t_order;
      t_fill_ab;
      t_fill_ba;
      t_underflow;
      t_simul;
      t_flags;
      t_irq;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule